// File: doc/BRIEF.md
# Integer Execute Unit for 32-bit Base-Integer Instructions

This block computes the result of one integer computational instruction at a time. It takes the raw 32-bit instruction word, the two source-operand values read from the register file, and the program counter of the instruction. It returns the value to write back, the destination register index, a write enable and an illegal-instruction flag. The block covers the register-immediate group, the register-register group, load-upper-immediate and add-upper-immediate-to-PC. It decodes the opcode, func3 and func7 fields directly and forms the sign-extended immediates itself.

The datapath is combinational. When the `OUT_REG` parameter is 1, a single register stage sits at the output. In that case `out_valid` follows `in_valid` by one clock cycle. When `OUT_REG` is 0, `out_valid` follows `in_valid` in the same cycle. A valid instruction moves through two phases: decode, which selects the operation, the operand sources and the immediate, and execute, which applies the ALU. There is no other sequencing.

Top module: `rvx_exec_unit`

## Requirements
- R1: Opcode 0110011 with func7 0000000 and func3 000 gives rs1+rs2. With func7 0100000 (bit 30 set) and func3 000 it gives rs1-rs2. Opcode 0010011 with func3 000 gives rs1+imm. All arithmetic wraps modulo 2^32.
- R2: The 12-bit immediate in instruction bits 31:20 is sign-extended from bit 31 to 32 bits before use.
- R3: Shifts use func3 001 for left and 101 for right. The register forms take the shift amount from rs2[4:0], and bit 30 set selects arithmetic right over logical right. The immediate forms take the amount from imm[4:0]. They shift right arithmetically only when imm[11:5] equals 0100000, and logically for any other value.
- R4: func3 010 (SLT/SLTI) compares signed and func3 011 (SLTU/SLTIU) compares unsigned. The result is 1 or 0. SLTIU with immediate 1 gives 1 exactly when rs1 is zero.
- R5: func3 100, 110 and 111 give XOR, OR and AND, in both the register and the immediate forms. XOR with immediate -1 gives the bitwise complement of rs1.
- R6: Opcode 0110111 writes {instr[31:12], 12'h000}. Opcode 0010111 writes that same value plus the PC.
- R7: When the destination field instr[11:7] is 0, the write enable stays low. ADDI x0,x0,0 is therefore a no-operation.
- R8: A source field (instr[19:15] or instr[24:20]) equal to 0 reads as zero, whatever value is presented on the matching operand input.
- R9: Any opcode other than 0010011, 0110011, 0110111 and 0010111 raises the illegal flag, holds the write enable low and gives a result of 0.
- R10: Opcode 0110011 with func7 outside {0000000, 0100000}, or with func7 0100000 and func3 other than 000 or 101, is illegal. In that case the write enable is low and the result is 0.
- R11: With `OUT_REG`=1, the outputs for an instruction appear one cycle after it is presented with `in_valid`. `out_valid` and `wr_en` are low when no instruction is presented and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source operand value |
| rs2_val | input | 32 | Second source operand value |
| pc | input | 32 | Address of the instruction |
| out_valid | output | 1 | A result is presented |
| result | output | 32 | Value to write back |
| rd_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write-back enable |
| illegal | output | 1 | Instruction not in the supported space |

## Verification
The hardest situations to reach from the ports are the encodings that differ from a legal instruction in a single bit. Examples are an immediate right shift with imm[11:5] one bit away from 0100000, which must stay logical, and a register operation with func7 0000001, which must be illegal. The stimulus builds these words directly with field-level encoder functions. It also drives non-zero operand values while the matching source field is zero. This shows at the result port that those values are ignored.

// File: rtl/rvx_pkg.sv
package rvx_pkg;

    localparam int XLEN = 32;
    localparam int IW   = 32;
    localparam int RIW  = 5;

    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_OPREG = 7'b0110011;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;
    localparam logic [6:0] F7_BASE   = 7'b0000000;
    localparam logic [6:0] F7_ALT    = 7'b0100000;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_RS1, SRC_PC, SRC_ZERO
    } a_sel_e;

    typedef struct packed {
        alu_op_e         op;
        a_sel_e          a_sel;
        logic            b_imm;
        logic [XLEN-1:0] imm;
        logic [RIW-1:0]  rd;
        logic            rs1_zero;
        logic            rs2_zero;
        logic            ill;
    } dec_t;

endpackage

// File: rtl/rvx_decode.sv
module rvx_decode
    import rvx_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);

    logic [6:0]      opcode;
    logic [2:0]      f3;
    logic [6:0]      f7;
    logic [XLEN-1:0] imm_i;
    logic [XLEN-1:0] imm_u;

    assign opcode = instr[6:0];
    assign f3     = instr[14:12];
    assign f7     = instr[31:25];
    assign imm_i  = {{(XLEN-12){instr[31]}}, instr[31:20]};
    assign imm_u  = {instr[31:12], 12'h000};

    function automatic alu_op_e base_op(input logic [2:0] fn);
        unique case (fn)
            3'b000:  base_op = ALU_ADD;
            3'b001:  base_op = ALU_SLL;
            3'b010:  base_op = ALU_SLT;
            3'b011:  base_op = ALU_SLTU;
            3'b100:  base_op = ALU_XOR;
            3'b101:  base_op = ALU_SRL;
            3'b110:  base_op = ALU_OR;
            default: base_op = ALU_AND;
        endcase
    endfunction

    always_comb begin
        dec          = '0;
        dec.op       = ALU_ADD;
        dec.a_sel    = SRC_RS1;
        dec.rd       = instr[11:7];
        dec.rs1_zero = (instr[19:15] == '0);
        dec.rs2_zero = (instr[24:20] == '0);
        unique case (opcode)
            OPC_OPIMM: begin
                dec.b_imm = 1'b1;
                dec.imm   = imm_i;
                dec.op    = base_op(f3);
                if (f3 == 3'b101 && f7 == F7_ALT) dec.op = ALU_SRA;
            end
            OPC_OPREG: begin
                if (f7 == F7_BASE)                   dec.op  = base_op(f3);
                else if (f7 == F7_ALT && f3 == 3'b000) dec.op  = ALU_SUB;
                else if (f7 == F7_ALT && f3 == 3'b101) dec.op  = ALU_SRA;
                else                                 dec.ill = 1'b1;
            end
            OPC_LUI: begin
                dec.b_imm = 1'b1;
                dec.imm   = imm_u;
                dec.a_sel = SRC_ZERO;
            end
            OPC_AUIPC: begin
                dec.b_imm = 1'b1;
                dec.imm   = imm_u;
                dec.a_sel = SRC_PC;
            end
            default: dec.ill = 1'b1;
        endcase
    end

endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
    import rvx_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << sh;
            ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> sh;
            ALU_SRA:  y = W'($signed(a) >>> sh);
            ALU_OR:   y = a | b;
            default:  y = a & b;
        endcase
    end

    always_comb begin
        if (op == ALU_SLT || op == ALU_SLTU)
            AST_CMP_SINGLE_BIT: assert (y[W-1:1] == '0); // R4
        if (op == ALU_SUB)
            AST_SUB_INVERTS_ADD: assert (y + b == a); // R1
    end

endmodule

// File: rtl/rvx_exec_unit.sv
module rvx_exec_unit
    import rvx_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IW-1:0]   instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] pc,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic [RIW-1:0]  rd_idx,
    output logic            wr_en,
    output logic            illegal
);

    dec_t            dec;
    logic [XLEN-1:0] rs1_eff;
    logic [XLEN-1:0] rs2_eff;
    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] c_result;
    logic            c_we;

    rvx_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign rs1_eff = dec.rs1_zero ? '0 : rs1_val;
    assign rs2_eff = dec.rs2_zero ? '0 : rs2_val;

    always_comb begin
        unique case (dec.a_sel)
            SRC_PC:   op_a = pc;
            SRC_ZERO: op_a = '0;
            default:  op_a = rs1_eff;
        endcase
        op_b = dec.b_imm ? dec.imm : rs2_eff;
    end

    rvx_alu #(.W(XLEN)) u_alu (
        .op (dec.op),
        .a  (op_a),
        .b  (op_b),
        .y  (alu_y)
    );

    assign c_result = dec.ill ? '0 : alu_y;
    assign c_we     = in_valid && !dec.ill && (dec.rd != '0);

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    result    <= '0;
                    rd_idx    <= '0;
                    wr_en     <= 1'b0;
                    illegal   <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    result    <= c_result;
                    rd_idx    <= dec.rd;
                    wr_en     <= c_we;
                    illegal   <= in_valid && dec.ill;
                end
            end
        end else begin : g_comb
            assign out_valid = in_valid;
            assign result    = c_result;
            assign rd_idx    = dec.rd;
            assign wr_en     = c_we;
            assign illegal   = in_valid && dec.ill;
        end
    endgenerate

    AST_X0_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_idx != '0)); // R7
    AST_ILLEGAL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && result == '0)); // R9
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !wr_en); // R11

endmodule

// File: tb/rvx_exec_unit_bench.sv
module rvx_exec_unit_bench;

    localparam logic [6:0] OPI = 7'b0010011;
    localparam logic [6:0] OPR = 7'b0110011;
    localparam logic [6:0] LUI = 7'b0110111;
    localparam logic [6:0] AUI = 7'b0010111;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  rd;
        logic        we;
        logic        ill;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [31:0] pc = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  rd_idx;
    logic        wr_en;
    logic        illegal;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    rvx_exec_unit u_rvx_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc),
        .out_valid(out_valid), .result(result), .rd_idx(rd_idx),
        .wr_en(wr_en), .illegal(illegal)
    );

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] s2, logic [4:0] s1,
                                          logic [2:0] f3, logic [4:0] d, logic [6:0] op);
        return {f7, s2, s1, f3, d, op};
    endfunction
    function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] s1, logic [2:0] f3,
                                          logic [4:0] d, logic [6:0] op);
        return {im, s1, f3, d, op};
    endfunction
    function automatic logic [31:0] enc_u(logic [19:0] im, logic [4:0] d, logic [6:0] op);
        return {im, d, op};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] p, input logic [31:0] er, input logic ewe,
                         input logic eil, input string req);
        exp_t e;
        @(posedge clk);
        #2;
        in_valid = 1'b1; instr = iw; rs1_val = a; rs2_val = b; pc = p;
        e.res = er; e.rd = iw[11:7]; e.we = ewe; e.ill = eil; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        instr = 32'hFFFF_FFFF;
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11", "out_valid with nothing presented", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result == e.res, e.req, "result", result, e.res);
                    check(wr_en == e.we, e.req, "wr_en", 32'(wr_en), 32'(e.we));
                    check(illegal == e.ill, e.req, "illegal", 32'(illegal), 32'(e.ill));
                    check(rd_idx == e.rd, e.req, "rd_idx", 32'(rd_idx), 32'(e.rd));
                end
            end else begin
                check(!wr_en, "R11", "wr_en while idle", 32'(wr_en), 32'd0);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && !wr_en && !illegal, "R11", "reset outputs",
              {29'd0, out_valid, wr_en, illegal}, 32'd0);
        rst_n = 1'b1;

        // R1
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, OPR), 32'd5, 32'd7, 0, 32'd12, 1, 0, "R1");
        drive(enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd3, OPR), 32'd5, 32'd7, 0, 32'hFFFF_FFFE, 1, 0, "R1");
        drive(enc_i(12'd100, 5'd1, 3'b000, 5'd9, OPI), 32'hFFFF_FFFF, 0, 0, 32'd99, 1, 0, "R1");
        // R2
        drive(enc_i(12'hFFD, 5'd1, 3'b000, 5'd4, OPI), 32'd10, 0, 0, 32'd7, 1, 0, "R2");
        drive(enc_i(12'h800, 5'd1, 3'b000, 5'd4, OPI), 32'd0, 0, 0, 32'hFFFF_F800, 1, 0, "R2");
        // R3
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b001, 5'd5, OPR), 32'd1, 32'h23, 0, 32'd8, 1, 0, "R3");
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b101, 5'd5, OPR), 32'h8000_0000, 32'd4, 0, 32'h0800_0000, 1, 0, "R3");
        drive(enc_r(7'h20, 5'd2, 5'd1, 3'b101, 5'd5, OPR), 32'h8000_0000, 32'd4, 0, 32'hF800_0000, 1, 0, "R3");
        drive(enc_i(12'h41F, 5'd1, 3'b101, 5'd5, OPI), 32'h8000_0000, 0, 0, 32'hFFFF_FFFF, 1, 0, "R3");
        drive(enc_i(12'h01F, 5'd1, 3'b101, 5'd5, OPI), 32'h8000_0000, 0, 0, 32'd1, 1, 0, "R3");
        drive(enc_i(12'h021, 5'd1, 3'b101, 5'd5, OPI), 32'h8000_0000, 0, 0, 32'h4000_0000, 1, 0, "R3");
        drive(enc_i(12'h004, 5'd1, 3'b001, 5'd5, OPI), 32'h0000_000F, 0, 0, 32'h0000_00F0, 1, 0, "R3");
        idle();
        // R4
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b010, 5'd6, OPR), 32'hFFFF_FFFF, 32'd1, 0, 32'd1, 1, 0, "R4");
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b011, 5'd6, OPR), 32'hFFFF_FFFF, 32'd1, 0, 32'd0, 1, 0, "R4");
        drive(enc_i(12'hFFC, 5'd1, 3'b010, 5'd6, OPI), 32'hFFFF_FFFB, 0, 0, 32'd1, 1, 0, "R4");
        drive(enc_i(12'hFFF, 5'd1, 3'b011, 5'd6, OPI), 32'd5, 0, 0, 32'd1, 1, 0, "R4");
        drive(enc_i(12'h001, 5'd1, 3'b011, 5'd6, OPI), 32'd0, 0, 0, 32'd1, 1, 0, "R4");
        drive(enc_i(12'h001, 5'd1, 3'b011, 5'd6, OPI), 32'd7, 0, 0, 32'd0, 1, 0, "R4");
        // R5
        drive(enc_i(12'hFFF, 5'd1, 3'b100, 5'd7, OPI), 32'h1234_5678, 0, 0, 32'hEDCB_A987, 1, 0, "R5");
        drive(enc_i(12'h0F0, 5'd1, 3'b111, 5'd7, OPI), 32'h0000_FFFF, 0, 0, 32'h0000_00F0, 1, 0, "R5");
        drive(enc_i(12'h800, 5'd1, 3'b110, 5'd7, OPI), 32'd1, 0, 0, 32'hFFFF_F801, 1, 0, "R5");
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd7, OPR), 32'hF0F0, 32'h0FF0, 0, 32'h00F0, 1, 0, "R5");
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd7, OPR), 32'hF0F0, 32'h0FF0, 0, 32'hFFF0, 1, 0, "R5");
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b100, 5'd7, OPR), 32'hF0F0, 32'h0FF0, 0, 32'hFF00, 1, 0, "R5");
        // R6
        drive(enc_u(20'hABCDE, 5'd8, LUI), 32'h1111_1111, 0, 32'h40, 32'hABCD_E000, 1, 0, "R6");
        drive(enc_u(20'h00001, 5'd8, AUI), 0, 0, 32'h100, 32'h0000_1100, 1, 0, "R6");
        drive(enc_u(20'hFFFFF, 5'd8, AUI), 0, 0, 32'h2000, 32'h0000_1000, 1, 0, "R6");
        // R7
        drive(enc_i(12'h000, 5'd0, 3'b000, 5'd0, OPI), 32'h55, 0, 0, 32'd0, 0, 0, "R7");
        drive(enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd0, OPR), 32'd5, 32'd6, 0, 32'd11, 0, 0, "R7");
        // R8
        drive(enc_i(12'd5, 5'd0, 3'b000, 5'd4, OPI), 32'hDEAD, 0, 0, 32'd5, 1, 0, "R8");
        drive(enc_r(7'h00, 5'd0, 5'd1, 3'b000, 5'd4, OPR), 32'd3, 32'd99, 0, 32'd3, 1, 0, "R8");
        // R9
        drive(enc_i(12'd4, 5'd1, 3'b010, 5'd3, 7'b0000011), 32'd8, 0, 0, 32'd0, 0, 1, "R9");
        drive(enc_u(20'h00010, 5'd1, 7'b1101111), 0, 0, 32'h80, 32'd0, 0, 1, "R9");
        // R10
        drive(enc_r(7'h01, 5'd2, 5'd1, 3'b000, 5'd3, OPR), 32'd5, 32'd7, 0, 32'd0, 0, 1, "R10");
        drive(enc_r(7'h20, 5'd2, 5'd1, 3'b111, 5'd3, OPR), 32'd5, 32'd7, 0, 32'd0, 0, 1, "R10");
        idle();
        idle();
        idle();
        check(sb.size() == 0, "R11", "results outstanding", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule